// File: doc/BRIEF.md
# GPIO Edge and Level Event Detector

This block watches two banks of 32 general-purpose input pins and records, per pin, whether a selected condition has occurred. Every pin has six independent enable bits. Four of them watch the fully synchronized input: a low-to-high transition, a high-to-low transition, a high level and a low level. The remaining two catch early edges. They compare the first synchronizer stage with the second, so a transition is seen one clock before the synchronous edge detectors see it.

A detected condition sets a sticky bit in the bank's status word. Software clears a bit by writing a 1 to it, and writing 0 leaves a bit untouched. Each bank raises its own interrupt line for as long as any status bit in that bank is set. After reset all enables are zero. Software programs the enables, then services interrupts by reading the status word and writing back the bits it has handled.

The register port is a plain single-cycle write port with a combinational read path. The offsets are fixed, because software decodes them. Bank 1's copy of each register sits 4 bytes above bank 0's copy.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset every enable register and both status words read 0, and both interrupt outputs are low.
- R2: Enable registers are read/write 32-bit words. They sit at offsets 0x4C (rising), 0x58 (falling), 0x64 (high level), 0x70 (low level), 0x7C (early rising) and 0x88 (early falling) for bank 0, with bank 1 at offset+4. The status words are at 0x40 and 0x44. Reads of any other offset return 0.
- R3: With the rising enable bit of a pin set, a low-to-high change on that pin made between clock edges sets the pin's status bit at the third rising clock edge after the change. A high-to-low change does not set it.
- R4: With the falling enable bit set, a high-to-low change sets the status bit at the third rising edge. A low-to-high change does not set it.
- R5: With both the rising and the falling enable bits set, each transition in either direction sets the status bit.
- R6: With the high (or low) level enable set, the status bit sets while the synchronized pin is high (or low). If it is cleared while the level persists, it sets again.
- R7: The early rising and early falling enables set the status bit at the second rising edge after the change. This is one cycle ahead of R3/R4.
- R8: Writing a status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R9: If a new event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: Status bits stay set when their enables are later cleared. A pin whose enables are all clear never sets its status bit.
- R11: Each bank's interrupt output is high exactly while any status bit of that bank is set. Events in one bank do not affect the other bank's interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pin_in | input | 64 | Raw pin inputs, bank 0 in bits 31:0 |
| irq | output | 2 | Per-bank interrupt, bit b for bank b |

## Verification
The bench counts clock edges from a pin change to the status bit. A design that took the early edge from the wrong synchronizer stage would show up at the wrong cycle. So would a design that added or dropped a register. A clearing write is placed in the same cycle as a fresh early edge: a clear-wins design would lose that event. A clear is also issued while a level condition persists, and a design that blocked re-arming would leave the bit low. Enables are cleared while status bits are still set, which exposes any design that masks status with the enables. Table vectors place events on both banks, including bit 31 of bank 1, and check that only the owning bank's interrupt rises.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int NUM_KINDS = 6;
  // kind index: 0 rise, 1 fall, 2 high, 3 low, 4 early rise, 5 early fall
  localparam logic [7:0] EN_BASE [NUM_KINDS] = '{8'h4C, 8'h58, 8'h64, 8'h70, 8'h7C, 8'h88};
  localparam logic [7:0] ST_BASE = 8'h40;
  localparam int BANK_STRIDE = 4;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] s1,
  output logic [W-1:0] s2,
  output logic [W-1:0] s3
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  // R7: an early rising edge is followed one cycle later by the synchronous one
  assert_early_leads_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(s1 & ~s2)) |=> ((s2 & ~s3 & $past(s1 & ~s2)) == $past(s1 & ~s2)));
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int W = 32,
  parameter int K = 6
) (
  input  logic [W-1:0]        s1,
  input  logic [W-1:0]        s2,
  input  logic [W-1:0]        s3,
  input  logic [K-1:0][W-1:0] en,
  output logic [W-1:0]        evt
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      logic sync_up, sync_dn, early_up, early_dn;
      assign sync_up  = s2[i] & ~s3[i];
      assign sync_dn  = ~s2[i] & s3[i];
      assign early_up = s1[i] & ~s2[i];
      assign early_dn = ~s1[i] & s2[i];
      assign evt[i] = (en[0][i] & sync_up)  | (en[1][i] & sync_dn) |
                      (en[2][i] & s2[i])    | (en[3][i] & ~s2[i])  |
                      (en[4][i] & early_up) | (en[5][i] & early_dn);
    end
  endgenerate
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
  parameter int W        = 32,
  parameter int AW       = 8,
  parameter int BANK_IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  s1,
  input  logic [W-1:0]  s2,
  input  logic [W-1:0]  s3,
  output logic [W-1:0]  rdata,
  output logic          irq_o
);
  import gpio_evt_pkg::*;
  localparam int K   = NUM_KINDS;
  localparam int OFS = BANK_STRIDE * BANK_IDX;
  localparam logic [AW-1:0] ST_ADDR = AW'(int'(ST_BASE) + OFS);

  logic [K-1:0][W-1:0] en_q;
  logic [W-1:0]        status_q;
  logic [W-1:0]        evt;
  logic [W-1:0]        clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (we) begin
      for (int k = 0; k < K; k++) begin
        if (addr == AW'(int'(EN_BASE[k]) + OFS)) en_q[k] <= wdata;
      end
    end
  end

  gpio_evt_detect #(.W(W), .K(K)) det_i (
    .s1(s1), .s2(s2), .s3(s3), .en(en_q), .evt(evt)
  );

  assign clr_mask = (we && addr == ST_ADDR) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_mask) | evt;
  end

  assign irq_o = |status_q;

  always_comb begin
    rdata = '0;
    if (addr == ST_ADDR) rdata = status_q;
    for (int k = 0; k < K; k++) begin
      if (addr == AW'(int'(EN_BASE[k]) + OFS)) rdata = en_q[k];
    end
  end

  assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt)));
  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((status_q & $past(clr_mask & ~evt)) == '0));
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_q) |=> ((($past(status_q) & ~$past(clr_mask)) & ~status_q) == '0));
  assert_no_spurious_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~status_q)) |=> ((status_q & ~$past(status_q) & ~$past(evt)) == '0));
  assert_irq_falls_on_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(|clr_mask));
endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
  parameter int NUM_BANKS = 2,
  parameter int W         = 32,
  parameter int AW        = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [W-1:0]          reg_wdata,
  output logic [W-1:0]          reg_rdata,
  input  logic [NUM_BANKS*W-1:0] pin_in,
  output logic [NUM_BANKS-1:0]  irq
);
  localparam int NPINS = NUM_BANKS * W;

  logic [NPINS-1:0] s1, s2, s3;
  logic [NUM_BANKS-1:0][W-1:0] bank_rd;

  gpio_evt_sync #(.W(NPINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .s1(s1), .s2(s2), .s3(s3)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      gpio_evt_bank #(.W(W), .AW(AW), .BANK_IDX(b)) bank_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .s1(s1[b*W +: W]), .s2(s2[b*W +: W]), .s3(s3[b*W +: W]),
        .rdata(bank_rd[b]), .irq_o(irq[b])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_BANKS; i++) reg_rdata = reg_rdata | bank_rd[i];
  end

  assert_irq_low_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (irq == '0));
endmodule

// File: tb/gpio_evt_unit_tb_top.sv
module gpio_evt_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] pin_v = '0;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;

  gpio_evt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_v), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {kind[2:0], bank, pin[4:0], start level, end level, expect set}
  localparam logic [11:0] VECS [9] = '{
    {3'd0, 1'b0, 5'd3,  1'b0, 1'b1, 1'b1},
    {3'd0, 1'b0, 5'd3,  1'b1, 1'b0, 1'b0},
    {3'd1, 1'b0, 5'd7,  1'b1, 1'b0, 1'b1},
    {3'd1, 1'b1, 5'd31, 1'b0, 1'b1, 1'b0},
    {3'd2, 1'b1, 5'd0,  1'b0, 1'b1, 1'b1},
    {3'd3, 1'b0, 5'd31, 1'b1, 1'b0, 1'b1},
    {3'd4, 1'b1, 5'd12, 1'b0, 1'b1, 1'b1},
    {3'd5, 1'b0, 5'd20, 1'b1, 1'b0, 1'b1},
    {3'd5, 1'b1, 5'd5,  1'b0, 1'b1, 1'b0}
  };

  function automatic logic [7:0] en_addr(int kind, int bank);
    logic [7:0] base;
    case (kind)
      0: base = 8'h4C;
      1: base = 8'h58;
      2: base = 8'h64;
      3: base = 8'h70;
      4: base = 8'h7C;
      default: base = 8'h88;
    endcase
    return base + 8'(4 * bank);
  endfunction

  function automatic logic [7:0] st_addr(int bank);
    return 8'h40 + 8'(4 * bank);
  endfunction

  function automatic string kind_tag(int kind);
    case (kind)
      0: return "R3";
      1: return "R4";
      2, 3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean();
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 6; k++) wr(en_addr(k, b), 32'h0);
    @(negedge clk); pin_v = '0;
    idle(4);
    wr(st_addr(0), 32'hFFFF_FFFF);
    wr(st_addr(1), 32'hFFFF_FFFF);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 6; k++) begin rd(en_addr(k, b), d); chk("R1 enable reset", d, 0); end
      rd(st_addr(b), d); chk("R1 status reset", d, 0);
    end
    chk("R1 irq reset", {30'd0, irq}, 0);

    // R2 register readback and unmapped offsets
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 6; k++) begin
        wr(en_addr(k, b), 32'hA5A5_0F00 ^ 32'(k * 17 + b));
        rd(en_addr(k, b), d);
        chk("R2 enable readback", d, 32'hA5A5_0F00 ^ 32'(k * 17 + b));
      end
    rd(8'h00, d); chk("R2 unmapped 0x00", d, 0);
    rd(8'h48, d); chk("R2 unmapped 0x48", d, 0);
    clean();

    // table of single-pin vectors
    for (int v = 0; v < 9; v++) begin
      int kind, bank, pin;
      logic [31:0] expw;
      kind = int'(VECS[v][11:9]); bank = int'(VECS[v][8]); pin = int'(VECS[v][7:3]);
      clean();
      @(negedge clk); pin_v[bank*32 + pin] = VECS[v][2];
      idle(4);
      wr(st_addr(bank), 32'hFFFF_FFFF);
      wr(en_addr(kind, bank), 32'h1 << pin);
      @(negedge clk); pin_v[bank*32 + pin] = VECS[v][1];
      idle(5);
      expw = VECS[v][0] ? (32'h1 << pin) : 32'h0;
      rd(st_addr(bank), d);
      chk(kind_tag(kind), d, expw);
      chk("R11 owning irq", {31'd0, irq[bank]}, {31'd0, VECS[v][0]});
      chk("R11 other irq", {31'd0, irq[1-bank]}, 0);
    end

    // R7 early edge one cycle ahead of R3 synchronous edge
    clean();
    wr(en_addr(0, 0), 32'h2);
    wr(en_addr(4, 0), 32'h4);
    @(negedge clk); reg_addr = st_addr(0); pin_v[2:1] = 2'b11;
    @(posedge clk); @(posedge clk); @(negedge clk); #1;
    chk("R7 early edge at 2nd edge", reg_rdata, 32'h4);
    @(posedge clk); @(negedge clk); #1;
    chk("R3 sync edge at 3rd edge", reg_rdata, 32'h6);

    // R5 both edges
    clean();
    wr(en_addr(0, 0), 32'h200);
    wr(en_addr(1, 0), 32'h200);
    @(negedge clk); pin_v[9] = 1'b1; idle(4);
    rd(st_addr(0), d); chk("R5 rise with both", d, 32'h200);
    wr(st_addr(0), 32'h200);
    @(negedge clk); pin_v[9] = 1'b0; idle(4);
    rd(st_addr(0), d); chk("R5 fall with both", d, 32'h200);

    // R8 write-one-to-clear
    wr(en_addr(1, 0), 32'h0);
    wr(en_addr(0, 0), 32'h0C00);
    @(negedge clk); pin_v[11:10] = 2'b11; idle(4);
    wr(st_addr(0), 32'h0);
    rd(st_addr(0), d); chk("R8 zero write keeps", d, 32'h0E00);
    wr(st_addr(0), 32'h0400);
    rd(st_addr(0), d); chk("R8 one write clears bit", d, 32'h0A00);

    // R6 level persists after clear
    clean();
    wr(en_addr(2, 1), 32'h8);
    @(negedge clk); pin_v[32+3] = 1'b1; idle(4);
    wr(st_addr(1), 32'h8);
    rd(st_addr(1), d); chk("R6 level re-sets", d, 32'h8);
    chk("R11 bank1 irq", {30'd0, irq}, 32'h2);
    @(negedge clk); pin_v[32+3] = 1'b0; idle(4);
    wr(st_addr(1), 32'h8);
    rd(st_addr(1), d); chk("R6 clears after level gone", d, 0);
    chk("R11 irq drops", {30'd0, irq}, 0);

    // R9 event and clear in the same cycle
    clean();
    wr(en_addr(4, 0), 32'h10);
    @(negedge clk); pin_v[4] = 1'b1; idle(4);
    @(negedge clk); pin_v[4] = 1'b0; idle(4);
    rd(st_addr(0), d); chk("R9 setup status", d, 32'h10);
    @(negedge clk); pin_v[4] = 1'b1;
    @(posedge clk);
    @(negedge clk); reg_we = 1'b1; reg_addr = st_addr(0); reg_wdata = 32'h10;
    @(posedge clk);
    @(negedge clk); reg_we = 1'b0; #1;
    chk("R9 set wins", reg_rdata, 32'h10);
    wr(st_addr(0), 32'h10);
    rd(st_addr(0), d); chk("R8 plain clear", d, 0);

    // R10 sticky after disable, disabled pin ignored
    clean();
    wr(en_addr(0, 1), 32'h40);
    @(negedge clk); pin_v[32+6] = 1'b1; idle(4);
    wr(en_addr(0, 1), 32'h0);
    idle(2);
    rd(st_addr(1), d); chk("R10 sticky after disable", d, 32'h40);
    wr(st_addr(1), 32'h40);
    @(negedge clk); pin_v[32+6] = 1'b0; idle(2);
    @(negedge clk); pin_v[32+6] = 1'b1; idle(4);
    rd(st_addr(1), d); chk("R10 disabled pin ignored", d, 0);
    chk("R10 irq stays low", {30'd0, irq}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule